// File: doc/BRIEF.md
# Decimal Number Syntax Checker

This block watches a stream of ASCII bytes, one byte for each cycle in which the strobe is high. After every accepted byte it says whether everything seen since the last clear spells a well-formed decimal number. A well-formed number is one or more digits, optionally preceded by a single minus sign. It may then have a point followed by one or more further digits.

The recognizer is a six-state machine held in a flip-flop register. A combinational function of the current state and the incoming byte computes the next state. Any byte that the current state does not expect sends the machine to a trap state, and it stays there until the next clear. The valid flag is a decode of the registered state, so it changes on the same clock edge as the state. A synchronous clear starts a new string. The input after a clear is empty and is reported as not valid.

Top module: `decnum_recognizer`

## Requirements
- R1: While `rst` is high at a clock edge, the state becomes IDLE (code 0) and `num_ok` reads 0 after that edge. The empty string is reported as invalid.
- R2: State codes on `state_o` are IDLE=0, SIGN=1, WHOLE=2, POINT=3, FRAC=4 and TRAP=5. At an edge where `ch_vld` is low and `rst` is low, the state and `num_ok` keep their values whatever `ch` carries.
- R3: From IDLE, '-' (0x2D) moves to SIGN, a digit (0x30 to 0x39) moves to WHOLE, and any other byte moves to TRAP.
- R4: From SIGN, a digit moves to WHOLE and any other byte moves to TRAP.
- R5: From WHOLE, a digit stays in WHOLE, '.' (0x2E) moves to POINT, and any other byte moves to TRAP.
- R6: From POINT, a digit moves to FRAC and any other byte moves to TRAP.
- R7: From FRAC, a digit stays in FRAC and any other byte moves to TRAP.
- R8: TRAP stays TRAP for every byte until a clear.
- R9: `num_ok` is 1 exactly when the state is WHOLE or FRAC, and it changes on the same edge as the state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous clear to IDLE |
| ch | input | 8 | ASCII byte |
| ch_vld | input | 1 | Byte strobe; `ch` is consumed when high |
| num_ok | output | 1 | Input since the last clear is a valid number |
| state_o | output | 3 | Current state code |

## Verification
The assertions assume that `rst` is high at the first clock edge, so the state register never holds an unknown code. They also assume that `ch` is a settled value whenever `ch_vld` is high. The bench drives `rst` from time zero and changes `ch` and `ch_vld` only on falling edges. Its idle cycles put garbage bytes on `ch` with the strobe low, so the hold property is tested against real data on the bus.

// File: rtl/decnum_recognizer.sv
module decnum_recognizer #(
  parameter int CHAR_W = 8,
  localparam int ST_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CHAR_W-1:0] ch,
  input  logic              ch_vld,
  output logic              num_ok,
  output logic [ST_W-1:0]   state_o
);

  typedef enum logic [ST_W-1:0] {
    S_IDLE  = 3'd0,
    S_SIGN  = 3'd1,
    S_WHOLE = 3'd2,
    S_POINT = 3'd3,
    S_FRAC  = 3'd4,
    S_TRAP  = 3'd5
  } st_t;

  st_t st_q, st_d;
  logic is_dig, is_neg, is_dot;

  assign is_dig = (ch >= CHAR_W'('h30)) && (ch <= CHAR_W'('h39));
  assign is_neg = (ch == CHAR_W'('h2D));
  assign is_dot = (ch == CHAR_W'('h2E));

  always_comb begin
    st_d = S_TRAP;
    unique case (st_q)
      S_IDLE:  if (is_neg) st_d = S_SIGN;  else if (is_dig) st_d = S_WHOLE;
      S_SIGN:  if (is_dig) st_d = S_WHOLE;
      S_WHOLE: if (is_dig) st_d = S_WHOLE; else if (is_dot) st_d = S_POINT;
      S_POINT: if (is_dig) st_d = S_FRAC;
      S_FRAC:  if (is_dig) st_d = S_FRAC;
      default: st_d = S_TRAP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         st_q <= S_IDLE;
    else if (ch_vld) st_q <= st_d;
  end

  assign num_ok  = (st_q == S_WHOLE) || (st_q == S_FRAC);
  assign state_o = st_q;

endmodule

// File: rtl/decnum_recognizer_chk.sv
module decnum_recognizer_chk #(
  parameter int CHAR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [CHAR_W-1:0] ch,
  input logic              ch_vld,
  input logic              num_ok,
  input logic [2:0]        state_o
);

  logic dig;
  assign dig = (ch >= CHAR_W'('h30)) && (ch <= CHAR_W'('h39));

  // R1
  clear_idle_chk: assert property (@(posedge clk) rst |=> (state_o == 3'd0 && !num_ok));

  // R2
  legal_code_chk: assert property (@(posedge clk) disable iff (rst) state_o <= 3'd5);

  // R2
  hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !ch_vld |=> ($stable(state_o) && $stable(num_ok)));

  // R5
  whole_bad_chk: assert property (@(posedge clk) disable iff (rst)
    (ch_vld && state_o == 3'd2 && !dig && ch != CHAR_W'('h2E)) |=> state_o == 3'd5);

  // R8
  trap_stay_chk: assert property (@(posedge clk) disable iff (rst)
    state_o == 3'd5 |=> state_o == 3'd5);

  // R9
  ok_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(num_ok) |-> ($past(ch_vld) && $past(dig)));

endmodule

bind decnum_recognizer decnum_recognizer_chk #(.CHAR_W(CHAR_W)) chk_i (
  .clk(clk), .rst(rst), .ch(ch), .ch_vld(ch_vld), .num_ok(num_ok), .state_o(state_o)
);

// File: tb/decnum_recognizer_tb_top.sv
module decnum_recognizer_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] ch = 8'h00;
  logic ch_vld = 1'b0;
  logic num_ok;
  logic [2:0] state_o;
  int total = 0;
  int bad = 0;
  bit done = 0;
  byte q[$];

  always #2.5 clk = ~clk;

  decnum_recognizer dut_i (
    .clk(clk), .rst(rst), .ch(ch), .ch_vld(ch_vld), .num_ok(num_ok), .state_o(state_o)
  );

  function automatic bit isd(byte c);
    return c >= 8'h30 && c <= 8'h39;
  endfunction

  function automatic int ref_state();
    int i = 0;
    int n = 0;
    int len = q.size();
    if (len == 0) return 0;
    if (q[0] == 8'h2D) i = 1;
    if (i == len) return 1;
    while (i < len && isd(q[i])) begin i++; n++; end
    if (n == 0) return 5;
    if (i == len) return 2;
    if (q[i] != 8'h2E) return 5;
    i++;
    if (i == len) return 3;
    n = 0;
    while (i < len && isd(q[i])) begin i++; n++; end
    if (n == 0 || i < len) return 5;
    return 4;
  endfunction

  task automatic check(string tag);
    int es = ref_state();
    bit eo = (es == 2 || es == 4);
    total++;
    if (state_o !== 3'(es) || num_ok !== eo) begin
      bad++;
      $display("FAIL %s: state=%0d ok=%0b expected state=%0d ok=%0b", tag, state_o, num_ok, es, eo);
    end
  endtask

  task automatic step(byte c, bit v, string tag);
    @(negedge clk);
    ch = c; ch_vld = v;
    @(posedge clk);
    if (v) q.push_back(c);
    #1 check(tag);
  endtask

  task automatic clear(string tag);
    @(negedge clk);
    rst = 1'b1; ch_vld = 1'b0;
    @(posedge clk);
    q.delete();
    #1 check(tag);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic feed(string s, string tag);
    clear("R1");
    for (int i = 0; i < s.len(); i++) step(s[i], 1'b1, tag);
  endtask

  initial begin
    repeat (2) @(posedge clk);
    #1 check("R1");
    clear("R1");
    step(8'h41, 1'b0, "R2");
    feed("-12.50", "R9");
    step(8'h2E, 1'b0, "R2");
    step(8'h7A, 1'b0, "R2");
    feed("7", "R3");
    feed("x", "R3");
    feed("-", "R3");
    feed("-a", "R4");
    feed("--1", "R4");
    feed("3.", "R5");
    feed("12a", "R5");
    feed("12-", "R5");
    feed(".5", "R3");
    feed("4..", "R6");
    feed("4.-", "R6");
    feed("0.0009", "R7");
    feed("1.2.3", "R7");
    feed("9.9/", "R7");
    feed("1a2345", "R8");
    step(8'h2E, 1'b1, "R8");
    feed("-9", "R9");
    step(8'h35, 1'b0, "R2");
    for (int k = 0; k < 3000; k++) begin
      byte cs[8] = '{8'h2D, 8'h2E, 8'h30, 8'h35, 8'h39, 8'h2F, 8'h3A, 8'h20};
      if ($urandom_range(0, 19) == 0) clear("R1");
      else step(cs[$urandom_range(0, 7)], $urandom_range(0, 3) != 0, "R9");
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule